// File: doc/BRIEF.md
# Event Timer Interrupt Router

This block sits behind a bank of timer comparators and turns their match events into interrupt requests. Every channel picks one of three delivery styles: a level request that stays up until software acknowledges it, a single-cycle pulse, or a 32-bit memory write whose address and data come from a per-channel 64-bit destination word. Level requests are recorded in a status vector. Software clears entries in that vector by writing ones to them.

A compatibility mode hands channel 0 and channel 1 to two fixed lines: line 0 and the real-time-clock line (`RTC_LINE`). While the mode is active, the block also masks the two external legacy interrupt sources that normally pass through onto those same lines. The real-time-clock input is tracked at all times, so its line shows the correct level again as soon as the mode is left. A registered output tells the external legacy timer whether it may drive its line. The timers' counters are outside this block.

All outputs are registered. A line or status change appears in the cycle after the edge that samples the cause. A message request appears one cycle later than that, because each request is first held as pending and then arbitrated.

Top module: `evr_router`

## Requirements
- R1: After a synchronous reset, all lines are low, the status vector is zero, `msg_valid_o` is low and `pit_en_o` is high.
- R2: An event on a channel in level style (`ch_level_i`=1, `ch_msg_en_i`=0) with both its own enable and the global enable high sets its status bit at the next edge. The bit holds the routed line high until it is cleared.
- R3: An event on a channel in pulse style (`ch_level_i`=0) drives its routed line high for exactly one cycle and clears that channel's status bit.
- R4: When the channel enable or the global enable is low, events are ignored. Lowering either enable clears the status bit and drops the line at the next edge.
- R5: A status write (`sts_wr_i`) clears the bits whose `sts_wdata_i` bit is 1 and drops their lines. Bits written with 0 are unchanged. A level event on a channel in the same cycle as a clear of its bit leaves the bit set.
- R6: Outside compatibility mode, a channel drives the line numbered by its `ch_route_i` field (channel c uses bits [c*RT_W +: RT_W]). Each line is the OR of all sources aimed at it. A field value of `N_LINES` or above drives no line.
- R7: In compatibility mode (`legacy_i`=1), channel 0 drives line 0 and channel 1 drives line `RTC_LINE` (default 8). The other channels keep their route field.
- R8: `pit_en_o` is low in the cycle after `legacy_i` is sampled high, and high in the cycle after it is sampled low.
- R9: Outside compatibility mode, `ext_pit_i` is ORed onto line 0 and `ext_rtc_i` onto line `RTC_LINE` with one cycle of latency. In the mode, both are masked. On leaving the mode, line `RTC_LINE` shows the current `ext_rtc_i` level at once.
- R10: An enabled event on a channel in message style (`ch_msg_en_i`=1) drives no line and leaves its status bit clear. Two edges later it raises `msg_valid_o` with `msg_addr_o` = bits [63:32] and `msg_data_o` = bits [31:0] of that channel's `ch_msg_cfg_i` word. Valid, address and data stay fixed until `msg_ready_i` is sampled high.
- R11: Message requests from several channels are issued lowest channel index first. A repeat event on a channel that is still pending merges into one write.
- R12: A rising `ch_msg_en_i` bit clears that channel's status bit and drops its line at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en_i | input | 1 | Global delivery enable |
| legacy_i | input | 1 | Compatibility mode select |
| ch_event_i | input | N_CH | Per-channel match event, one cycle per event |
| ch_enable_i | input | N_CH | Per-channel delivery enable |
| ch_level_i | input | N_CH | 1 = level style, 0 = pulse style |
| ch_msg_en_i | input | N_CH | 1 = deliver by message write |
| ch_route_i | input | N_CH*RT_W | Line number per channel |
| ch_msg_cfg_i | input | N_CH*64 | Per channel: address [63:32], data [31:0] |
| ext_pit_i | input | 1 | External legacy timer interrupt level |
| ext_rtc_i | input | 1 | External real-time-clock interrupt level |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | N_CH | Write-one-to-clear mask |
| msg_ready_i | input | 1 | Message sink accepts |
| irq_o | output | N_LINES | Interrupt lines |
| sts_o | output | N_CH | Status vector |
| pit_en_o | output | 1 | External legacy timer allowed to drive |
| msg_valid_o | output | 1 | Message write request |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The channels are configured with mixed styles, and two of them share one line. This separates a line that is held by the OR of several sources from one held by a single source, and it shows whether clearing one bit leaves a line up that another channel still holds. Compatibility mode is entered and left while the external inputs are high. This distinguishes masked pass-through from a stale stored level, and shows the fixed remap of channels 0 and 1 against their route fields. Simultaneous and repeated message events under back-pressure tell priority order, merging and hold-while-stalled apart from one another.

// File: rtl/evr_pkg.sv
package evr_pkg;

    localparam int MSG_AW = 32;
    localparam int MSG_DW = 32;
    localparam int CFG_W  = MSG_AW + MSG_DW;

    typedef struct packed {
        logic [MSG_AW-1:0] addr;
        logic [MSG_DW-1:0] data;
    } msg_t;

    typedef enum logic [1:0] {
        DLV_NONE  = 2'd0,
        DLV_LEVEL = 2'd1,
        DLV_PULSE = 2'd2,
        DLV_MSG   = 2'd3
    } dlv_e;

    function automatic dlv_e evr_classify(input logic fire, input logic level,
                                          input logic msg);
        if (!fire)      return DLV_NONE;
        else if (msg)   return DLV_MSG;
        else if (level) return DLV_LEVEL;
        else            return DLV_PULSE;
    endfunction

endpackage

// File: rtl/evr_status_bank.sv
module evr_status_bank
    import evr_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            glb_en_i,
    input  logic [N_CH-1:0] event_i,
    input  logic [N_CH-1:0] enable_i,
    input  logic [N_CH-1:0] level_i,
    input  logic [N_CH-1:0] msg_en_i,
    input  logic            sts_wr_i,
    input  logic [N_CH-1:0] sts_wdata_i,
    output logic [N_CH-1:0] sts_o,
    output logic [N_CH-1:0] line_src_o,
    output logic [N_CH-1:0] msg_fire_o,
    output logic [N_CH-1:0] msg_keep_o
);

    logic [N_CH-1:0] sts_q, sts_d, msg_en_q;
    dlv_e            kind [N_CH];

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic allow, msg_rise;
        assign allow    = enable_i[c] & glb_en_i;
        assign msg_rise = msg_en_i[c] & ~msg_en_q[c];
        assign kind[c]  = evr_classify(event_i[c] & allow, level_i[c], msg_en_i[c]);

        always_comb begin
            if (!allow)                          sts_d[c] = 1'b0;
            else if (msg_rise)                   sts_d[c] = 1'b0;
            else if (kind[c] == DLV_LEVEL)       sts_d[c] = 1'b1;
            else if (kind[c] == DLV_PULSE)       sts_d[c] = 1'b0;
            else if (sts_wr_i && sts_wdata_i[c]) sts_d[c] = 1'b0;
            else                                 sts_d[c] = sts_q[c];
        end

        assign line_src_o[c] = (sts_d[c] & level_i[c] & ~msg_en_i[c])
                             | (kind[c] == DLV_PULSE);
        assign msg_fire_o[c] = (kind[c] == DLV_MSG);
        assign msg_keep_o[c] = allow & msg_en_i[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q    <= '0;
            msg_en_q <= '0;
        end else begin
            sts_q    <= sts_d;
            msg_en_q <= msg_en_i;
        end
    end

    assign sts_o = sts_q;

endmodule

// File: rtl/evr_line_map.sv
module evr_line_map #(
    parameter int N_CH     = 4,
    parameter int N_LINES  = 24,
    parameter int RTC_LINE = 8,
    parameter int RT_W     = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               legacy_i,
    input  logic [N_CH-1:0]    src_i,
    input  logic [N_CH*RT_W-1:0] route_i,
    input  logic               ext_pit_i,
    input  logic               ext_rtc_i,
    output logic [N_LINES-1:0] irq_o,
    output logic               pit_en_o
);

    localparam logic [RT_W-1:0] RTC_DST = RT_W'(RTC_LINE);

    logic [RT_W-1:0]    dst [N_CH];
    logic [N_LINES-1:0] drv, irq_q;
    logic               pit_en_q;

    for (genvar c = 0; c < N_CH; c++) begin : g_dst
        if (c == 0) begin : g_c0
            assign dst[c] = legacy_i ? '0 : route_i[c*RT_W +: RT_W];
        end else if (c == 1) begin : g_c1
            assign dst[c] = legacy_i ? RTC_DST : route_i[c*RT_W +: RT_W];
        end else begin : g_cn
            assign dst[c] = route_i[c*RT_W +: RT_W];
        end
    end

    always_comb begin
        drv = '0;
        for (int l = 0; l < N_LINES; l++) begin
            for (int c = 0; c < N_CH; c++) begin
                if (src_i[c] && dst[c] == RT_W'(l)) drv[l] = 1'b1;
            end
        end
        if (!legacy_i) begin
            drv[0]        = drv[0] | ext_pit_i;
            drv[RTC_LINE] = drv[RTC_LINE] | ext_rtc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q    <= '0;
            pit_en_q <= 1'b1;
        end else begin
            irq_q    <= drv;
            pit_en_q <= ~legacy_i;
        end
    end

    assign irq_o    = irq_q;
    assign pit_en_o = pit_en_q;

endmodule

// File: rtl/evr_msg_port.sv
module evr_msg_port
    import evr_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_CH-1:0]       fire_i,
    input  logic [N_CH-1:0]       keep_i,
    input  logic [N_CH*CFG_W-1:0] cfg_i,
    input  logic                  ready_i,
    output logic                  valid_o,
    output msg_t                  msg_o
);

    logic [N_CH-1:0] pend_q, grant;
    logic            valid_q, load, found;
    msg_t            msg_q, pick;

    assign load = ~valid_q | ready_i;

    always_comb begin
        grant = '0;
        found = 1'b0;
        pick  = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (load && pend_q[c] && !found) begin
                grant[c] = 1'b1;
                found    = 1'b1;
                pick     = msg_t'(cfg_i[c*CFG_W +: CFG_W]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            valid_q <= 1'b0;
            msg_q   <= '0;
        end else begin
            pend_q <= ((pend_q & ~grant) | fire_i) & keep_i;
            if (load) begin
                valid_q <= found;
                if (found) msg_q <= pick;
            end
        end
    end

    assign valid_o = valid_q;
    assign msg_o   = msg_q;

endmodule

// File: rtl/evr_router.sv
module evr_router
    import evr_pkg::*;
#(
    parameter int N_CH     = 4,
    parameter int N_LINES  = 24,
    parameter int RTC_LINE = 8,
    parameter int RT_W     = $clog2(N_LINES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  glb_en_i,
    input  logic                  legacy_i,
    input  logic [N_CH-1:0]       ch_event_i,
    input  logic [N_CH-1:0]       ch_enable_i,
    input  logic [N_CH-1:0]       ch_level_i,
    input  logic [N_CH-1:0]       ch_msg_en_i,
    input  logic [N_CH*RT_W-1:0]  ch_route_i,
    input  logic [N_CH*64-1:0]    ch_msg_cfg_i,
    input  logic                  ext_pit_i,
    input  logic                  ext_rtc_i,
    input  logic                  sts_wr_i,
    input  logic [N_CH-1:0]       sts_wdata_i,
    input  logic                  msg_ready_i,
    output logic [N_LINES-1:0]    irq_o,
    output logic [N_CH-1:0]       sts_o,
    output logic                  pit_en_o,
    output logic                  msg_valid_o,
    output logic [31:0]           msg_addr_o,
    output logic [31:0]           msg_data_o
);

    logic [N_CH-1:0] line_src, msg_fire, msg_keep;
    msg_t            msg;

    evr_status_bank #(.N_CH(N_CH)) u_sts (
        .clk        (clk),
        .rst        (rst),
        .glb_en_i   (glb_en_i),
        .event_i    (ch_event_i),
        .enable_i   (ch_enable_i),
        .level_i    (ch_level_i),
        .msg_en_i   (ch_msg_en_i),
        .sts_wr_i   (sts_wr_i),
        .sts_wdata_i(sts_wdata_i),
        .sts_o      (sts_o),
        .line_src_o (line_src),
        .msg_fire_o (msg_fire),
        .msg_keep_o (msg_keep)
    );

    evr_line_map #(
        .N_CH(N_CH), .N_LINES(N_LINES), .RTC_LINE(RTC_LINE), .RT_W(RT_W)
    ) u_lines (
        .clk      (clk),
        .rst      (rst),
        .legacy_i (legacy_i),
        .src_i    (line_src),
        .route_i  (ch_route_i),
        .ext_pit_i(ext_pit_i),
        .ext_rtc_i(ext_rtc_i),
        .irq_o    (irq_o),
        .pit_en_o (pit_en_o)
    );

    evr_msg_port #(.N_CH(N_CH)) u_msg (
        .clk    (clk),
        .rst    (rst),
        .fire_i (msg_fire),
        .keep_i (msg_keep),
        .cfg_i  (ch_msg_cfg_i),
        .ready_i(msg_ready_i),
        .valid_o(msg_valid_o),
        .msg_o  (msg)
    );

    assign msg_addr_o = msg.addr;
    assign msg_data_o = msg.data;

endmodule

// File: rtl/evr_router_chk.sv
module evr_router_chk #(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            glb_en_i,
    input logic            legacy_i,
    input logic [N_CH-1:0] ch_event_i,
    input logic            sts_wr_i,
    input logic [N_CH-1:0] sts_wdata_i,
    input logic [N_CH-1:0] sts_o,
    input logic            pit_en_o,
    input logic            msg_valid_o,
    input logic            msg_ready_i,
    input logic [31:0]     msg_addr_o,
    input logic [31:0]     msg_data_o
);

    // R2: a status bit only rises after an event on that channel
    a_r2_set_needs_event: assert property (@(posedge clk) disable iff (rst)
        ((sts_o & ~$past(sts_o) & ~$past(ch_event_i)) == '0));

    // R4: global enable low empties the status vector
    a_r4_global_off: assert property (@(posedge clk) disable iff (rst)
        !glb_en_i |=> (sts_o == '0));

    // R5: written ones clear their bits when no event competes
    a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
        (sts_wr_i && ch_event_i == '0) |=> ((sts_o & $past(sts_wdata_i)) == '0));

    // R8: entering compatibility mode withdraws the legacy timer
    a_r8_pit_off: assert property (@(posedge clk) disable iff (rst)
        $rose(legacy_i) |=> !pit_en_o);

    // R10: a stalled request holds still
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (msg_valid_o && !msg_ready_i) |=>
        (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));

endmodule

bind evr_router evr_router_chk #(.N_CH(N_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .glb_en_i   (glb_en_i),
    .legacy_i   (legacy_i),
    .ch_event_i (ch_event_i),
    .sts_wr_i   (sts_wr_i),
    .sts_wdata_i(sts_wdata_i),
    .sts_o      (sts_o),
    .pit_en_o   (pit_en_o),
    .msg_valid_o(msg_valid_o),
    .msg_ready_i(msg_ready_i),
    .msg_addr_o (msg_addr_o),
    .msg_data_o (msg_data_o)
);

// File: tb/tb_evr_router.sv
module tb_evr_router;

    localparam int NC  = 4;
    localparam int NL  = 24;
    localparam int RTC = 8;
    localparam int RW  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic glb = 1'b0, legacy = 1'b0;
    logic [NC-1:0] evt = '0, en = '0, lvl = '0, msg = '0;
    logic [NC*RW-1:0] route = '0;
    logic [NC*64-1:0] cfg = '0;
    logic ext_pit = 1'b0, ext_rtc = 1'b0;
    logic sts_wr = 1'b0;
    logic [NC-1:0] wdata = '0;
    logic ready = 1'b0;

    logic [NL-1:0] irq_o;
    logic [NC-1:0] sts_o;
    logic pit_en_o, msg_valid_o;
    logic [31:0] msg_addr_o, msg_data_o;

    always #2 clk = ~clk;

    evr_router #(.N_CH(NC), .N_LINES(NL), .RTC_LINE(RTC)) dut (
        .clk(clk), .rst(rst), .glb_en_i(glb), .legacy_i(legacy),
        .ch_event_i(evt), .ch_enable_i(en), .ch_level_i(lvl), .ch_msg_en_i(msg),
        .ch_route_i(route), .ch_msg_cfg_i(cfg), .ext_pit_i(ext_pit), .ext_rtc_i(ext_rtc),
        .sts_wr_i(sts_wr), .sts_wdata_i(wdata), .msg_ready_i(ready),
        .irq_o(irq_o), .sts_o(sts_o), .pit_en_o(pit_en_o), .msg_valid_o(msg_valid_o),
        .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o)
    );

    int tests = 0, fails = 0;
    bit done = 1'b0;
    string req = "R1";

    // behavioural reference
    bit [NC-1:0] m_sts, m_msgq, m_pend;
    bit [NL-1:0] m_irq;
    bit m_pit = 1'b1, m_val;
    bit [31:0] m_addr, m_data;

    always @(posedge clk) begin
        if (rst) begin
            m_sts = '0; m_msgq = '0; m_pend = '0; m_irq = '0;
            m_pit = 1'b1; m_val = 1'b0; m_addr = '0; m_data = '0;
        end else begin
            bit [NC-1:0] ns, src, fire, keep;
            bit [NL-1:0] ni;
            bit al, ld;
            int d, g;
            ni = '0;
            for (int c = 0; c < NC; c++) begin
                al = en[c] & glb;
                fire[c] = evt[c] & al & msg[c];
                keep[c] = al & msg[c];
                if (!al) ns[c] = 0;
                else if (msg[c] && !m_msgq[c]) ns[c] = 0;
                else if (evt[c] && !msg[c]) ns[c] = lvl[c];
                else if (sts_wr && wdata[c]) ns[c] = 0;
                else ns[c] = m_sts[c];
                src[c] = (ns[c] & lvl[c] & !msg[c]) | (evt[c] & al & !msg[c] & !lvl[c]);
                if (legacy && c == 0) d = 0;
                else if (legacy && c == 1) d = RTC;
                else d = int'(route[c*RW +: RW]);
                if (src[c] && d < NL) ni[d] = 1'b1;
            end
            if (!legacy) begin
                if (ext_pit) ni[0] = 1'b1;
                if (ext_rtc) ni[RTC] = 1'b1;
            end
            ld = !m_val || ready;
            g = -1;
            if (ld) for (int c = 0; c < NC; c++) if (g < 0 && m_pend[c]) g = c;
            if (ld) begin
                m_val = (g >= 0);
                if (g >= 0) begin
                    m_addr = cfg[g*64+32 +: 32];
                    m_data = cfg[g*64 +: 32];
                end
            end
            if (g >= 0) m_pend[g] = 1'b0;
            m_pend = (m_pend | fire) & keep;
            m_sts = ns; m_irq = ni; m_msgq = msg; m_pit = !legacy;
        end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("irq", 64'(irq_o), 64'(m_irq));
        chk("sts", 64'(sts_o), 64'(m_sts));
        chk("pit_en", 64'(pit_en_o), 64'(m_pit));
        chk("msg_valid", 64'(msg_valid_o), 64'(m_val));
        if (m_val) begin
            chk("msg_addr", 64'(msg_addr_o), 64'(m_addr));
            chk("msg_data", 64'(msg_data_o), 64'(m_data));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic fire_evt(input logic [NC-1:0] m);
        evt = m;
        tick();
        evt = '0;
    endtask

    task automatic clr(input logic [NC-1:0] m);
        sts_wr = 1'b1; wdata = m;
        tick();
        sts_wr = 1'b0; wdata = '0;
    endtask

    initial begin
        repeat (3) tick();
        req = "R1";
        chk("reset irq", 64'(irq_o), 64'h0);
        chk("reset pit_en", 64'(pit_en_o), 64'h1);
        chk("reset valid", 64'(msg_valid_o), 64'h0);
        rst = 1'b0;
        glb = 1'b1; en = '1; lvl = 4'b0101;
        route[0*RW +: RW] = 5'd3; route[1*RW +: RW] = 5'd5;
        route[2*RW +: RW] = 5'd3; route[3*RW +: RW] = 5'd20;
        for (int c = 0; c < NC; c++) begin
            cfg[c*64+32 +: 32] = 32'hA000_0000 + 32'(c*16);
            cfg[c*64 +: 32]    = 32'hD000_0000 + 32'(c);
        end
        tick();

        req = "R2";
        fire_evt(4'b0001);
        chk("R2 line3 set", 64'(irq_o[3]), 64'h1);
        repeat (3) tick();
        chk("R2 line3 held", 64'(irq_o[3]), 64'h1);

        req = "R5";
        clr(4'b0100);
        chk("R5 zero-written bit kept", 64'(sts_o[0]), 64'h1);
        clr(4'b0001);
        chk("R5 cleared line3", 64'(irq_o[3]), 64'h0);
        evt = 4'b0001; clr(4'b0001); evt = '0;
        chk("R5 set wins over clear", 64'(sts_o[0]), 64'h1);
        tick();

        req = "R3";
        fire_evt(4'b0010);
        chk("R3 pulse high", 64'(irq_o[5]), 64'h1);
        tick();
        chk("R3 pulse one cycle", 64'(irq_o[5]), 64'h0);

        req = "R6";
        fire_evt(4'b0100);
        clr(4'b0100);
        chk("R6 line3 held by other source", 64'(irq_o[3]), 64'h1);
        clr(4'b0001);
        route[3*RW +: RW] = 5'd30;
        fire_evt(4'b1000);
        chk("R6 out-of-range route", 64'(irq_o), 64'h0);
        route[3*RW +: RW] = 5'd20;
        tick();

        req = "R4";
        glb = 1'b0;
        fire_evt(4'b0001);
        chk("R4 global off ignores", 64'(sts_o), 64'h0);
        glb = 1'b1;
        fire_evt(4'b0001);
        en[0] = 1'b0;
        tick();
        chk("R4 channel off clears", 64'(irq_o[3]), 64'h0);
        en[0] = 1'b1;
        tick();

        req = "R8";
        legacy = 1'b1;
        tick();
        chk("R8 pit_en low", 64'(pit_en_o), 64'h0);

        req = "R7";
        fire_evt(4'b1011);
        chk("R7 ch0 on line0", 64'(irq_o[0]), 64'h1);
        chk("R7 ch1 on rtc line", 64'(irq_o[RTC]), 64'h1);
        chk("R7 ch3 keeps route", 64'(irq_o[20]), 64'h1);
        tick();
        clr(4'b0001);

        req = "R9";
        ext_pit = 1'b1; ext_rtc = 1'b1;
        repeat (2) tick();
        chk("R9 masked in mode", 64'(irq_o), 64'h0);
        legacy = 1'b0;
        tick();
        chk("R9 rtc replayed", 64'(irq_o[RTC]), 64'h1);
        chk("R9 pit passes", 64'(irq_o[0]), 64'h1);
        ext_pit = 1'b0;
        tick();
        ext_rtc = 1'b0;
        tick();

        req = "R12";
        fire_evt(4'b0100);
        msg[2] = 1'b1;
        tick();
        chk("R12 status cleared", 64'(sts_o[2]), 64'h0);
        chk("R12 line dropped", 64'(irq_o[3]), 64'h0);

        req = "R10";
        ready = 1'b0;
        fire_evt(4'b0100);
        chk("R10 no line", 64'(irq_o), 64'h0);
        tick();
        chk("R10 addr", 64'(msg_addr_o), 64'hA000_0020);
        chk("R10 data", 64'(msg_data_o), 64'hD000_0002);
        repeat (3) tick();
        ready = 1'b1;
        repeat (2) tick();
        chk("R10 consumed", 64'(msg_valid_o), 64'h0);

        req = "R11";
        msg = '1; ready = 1'b0;
        tick();
        fire_evt(4'b1010);
        fire_evt(4'b1000);
        tick();
        chk("R11 lowest first", 64'(msg_data_o), 64'hD000_0001);
        ready = 1'b1;
        tick();
        chk("R11 next channel", 64'(msg_data_o), 64'hD000_0003);
        repeat (3) tick();
        chk("R11 merged repeat", 64'(msg_valid_o), 64'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule